// File: doc/BRIEF.md
# Sequential write burst coalescer

This block takes write cycles from a Wishbone-style slave port and turns them into tagged entries for a FIFO. The FIFO feeds a target bus that runs bursts with one address phase and then any number of data phases.

When the master raises its sequential-block flag and every address is the previous address plus four, the writes are packed into one burst entry group. The group is a start address, then data words, and the final word is tagged as the end. Any write without the flag, or any write that breaks the address run, goes out as a single transfer: one address entry followed by one final data word.

The block always holds back the newest accepted data word. Only the next event can tell whether that word continues the burst or ends it. The block therefore pushes the held word one step later, as a continuation or as the final word. When the FIFO has little room, the block inserts wait states rather than lose a write.

Top module: `wbc_burst_coalescer`

## Requirements
- R1: While reset is asserted, `wb_ack_o` and `fifo_push_o` stay low even with a write request present.
- R2: A write without the sequential flag is acknowledged in its request cycle. In that same cycle an entry with tag 2'b01 (address) carrying its address is pushed. In the next cycle its data is pushed with tag 2'b11 (final word).
- R3: In a flagged block, the first write pushes tag 2'b01 with its address. Each later write at the previous address plus 4 is acknowledged in its request cycle, and in that cycle the previously held data word is pushed with tag 2'b10 (continuation).
- R4: A flagged write whose address is not the previous address plus 4 gets no acknowledge in its first request cycle. In that cycle the held word is pushed with tag 2'b11. The write is accepted in the next cycle and opens a new entry group with its own address.
- R5: A write without the flag that arrives while a sequential burst is open also closes that burst as in R4, and is then issued as a single transfer.
- R6: A burst holds at most MAX_BEATS data words (16 by default). In the cycle after the last word is accepted, that word is pushed with tag 2'b11 without waiting for another write.
- R7: In the first cycle that `wb_cyc_i` is low while a burst is open, the held word is pushed with tag 2'b11.
- R8: A new entry group is only opened when `fifo_free_i` is at least 2. Until then the write is held off without acknowledge or push. An open burst is closed with tag 2'b11 as soon as `fifo_free_i` drops below 2. No acknowledged write is ever lost.
- R9: A request with `wb_we_i` low, or with `wb_cyc_i` low, is neither acknowledged nor pushes anything.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Transfer strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | W | Byte address |
| wb_dat_i | input | W | Write data |
| wb_seq_i | input | 1 | Master promises sequential addresses in this block |
| wb_ack_o | output | 1 | Transfer acknowledge (combinational) |
| fifo_free_i | input | FREEW | Free FIFO slots |
| fifo_push_o | output | 1 | Push one entry |
| fifo_tag_o | output | 2 | Entry tag: 01 address, 10 continuation, 11 final word |
| fifo_word_o | output | W | Entry payload (address or data) |

## Verification
Acknowledge and the address or continuation entry are due in the request cycle itself. The final-word entry is due one cycle after a closing event (cycle end, full length, low room or single transfer). An address break pushes the final word in the request cycle and acknowledges one cycle later. A monitor stamps every push with a cycle count taken at the falling clock edge, and the write task stamps its acknowledge the same way. Each scenario compares both the entry sequence and these stamps against the cycle offsets above.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    typedef enum logic [1:0] {
        TAG_NONE = 2'b00,
        TAG_ADDR = 2'b01,
        TAG_DATA = 2'b10,
        TAG_LAST = 2'b11
    } tag_e;
endpackage

// File: rtl/wbc_seq_check.sv
module wbc_seq_check #(
    parameter int W    = 32,
    parameter int STEP = 4
) (
    input  logic [W-1:0] adr_i,
    input  logic [W-1:0] expect_i,
    output logic         match_o,
    output logic [W-1:0] next_o
);
    always_comb begin
        match_o = (adr_i == expect_i);
        next_o  = adr_i + W'(STEP);
    end
endmodule

// File: rtl/wbc_burst_coalescer.sv
module wbc_burst_coalescer #(
    parameter int W         = 32,
    parameter int MAX_BEATS = 16,
    parameter int FREEW     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wb_cyc_i,
    input  logic             wb_stb_i,
    input  logic             wb_we_i,
    input  logic [W-1:0]     wb_adr_i,
    input  logic [W-1:0]     wb_dat_i,
    input  logic             wb_seq_i,
    output logic             wb_ack_o,
    input  logic [FREEW-1:0] fifo_free_i,
    output logic             fifo_push_o,
    output logic [1:0]       fifo_tag_o,
    output logic [W-1:0]     fifo_word_o
);
    import wbc_pkg::*;

    localparam int CNTW = $clog2(MAX_BEATS + 1);
    localparam int ROOM = 2;

    typedef struct packed {
        logic            open;
        logic            seq;
        logic [CNTW-1:0] cnt;
        logic [W-1:0]    nxt;
        logic [W-1:0]    held;
    } state_t;

    state_t s_d, s_q;
    logic   req, room, match, brk, close;
    logic [W-1:0] adr_next;
    tag_e   tag;

    wbc_seq_check #(.W(W), .STEP(4)) u_seq (
        .adr_i    (wb_adr_i),
        .expect_i (s_q.nxt),
        .match_o  (match),
        .next_o   (adr_next)
    );

    always_comb begin
        s_d         = s_q;
        fifo_push_o = 1'b0;
        tag         = TAG_NONE;
        fifo_word_o = '0;
        wb_ack_o    = 1'b0;
        req   = rst_n && wb_cyc_i && wb_stb_i && wb_we_i;
        room  = fifo_free_i >= FREEW'(ROOM);
        brk   = req && !(wb_seq_i && match);
        close = !wb_cyc_i || !s_q.seq || (s_q.cnt == CNTW'(MAX_BEATS)) || !room || brk;
        if (!rst_n) begin
            s_d = s_q;
        end else if (s_q.open) begin
            if (close) begin
                fifo_push_o = 1'b1;
                tag         = TAG_LAST;
                fifo_word_o = s_q.held;
                s_d.open    = 1'b0;
            end else if (req) begin
                fifo_push_o = 1'b1;
                tag         = TAG_DATA;
                fifo_word_o = s_q.held;
                s_d.held    = wb_dat_i;
                s_d.cnt     = s_q.cnt + CNTW'(1);
                s_d.nxt     = adr_next;
                wb_ack_o    = 1'b1;
            end
        end else if (req && room) begin
            fifo_push_o = 1'b1;
            tag         = TAG_ADDR;
            fifo_word_o = wb_adr_i;
            s_d.open    = 1'b1;
            s_d.seq     = wb_seq_i;
            s_d.cnt     = CNTW'(1);
            s_d.held    = wb_dat_i;
            s_d.nxt     = adr_next;
            wb_ack_o    = 1'b1;
        end
        fifo_tag_o = tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8: every acknowledged write leaves an entry in the same cycle
    p_ack_pushes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack_o |-> (fifo_push_o && fifo_tag_o != TAG_LAST));
    // R8: a new group only opens with room for address and final word
    p_addr_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push_o && fifo_tag_o == TAG_ADDR) |-> (fifo_free_i >= FREEW'(ROOM)));
    // R9: acknowledge only for a live write request
    p_ack_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack_o |-> (wb_cyc_i && wb_stb_i && wb_we_i));
    // R4: closing push never coincides with acceptance
    p_last_noack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push_o && fifo_tag_o == TAG_LAST) |-> !wb_ack_o);
    // R2: single transfer address is followed by its final word
    p_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push_o && fifo_tag_o == TAG_ADDR && !wb_seq_i) |=>
        (fifo_push_o && fifo_tag_o == TAG_LAST));
    // R7: cycle end right after an accepted write closes the burst
    p_cyc_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wb_cyc_i) && $past(wb_ack_o)) |-> (fifo_push_o && fifo_tag_o == TAG_LAST));
    // R6: the beat count never exceeds the burst limit
    p_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNTW'(MAX_BEATS));
endmodule

// File: tb/sim_wbc_burst_coalescer.sv
module sim_wbc_burst_coalescer;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int FREEW = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wb_cyc_i = 0, wb_stb_i = 0, wb_we_i = 0, wb_seq_i = 0;
    logic [W-1:0] wb_adr_i = '0, wb_dat_i = '0;
    logic [FREEW-1:0] fifo_free_i = 6'd16;
    logic wb_ack_o, fifo_push_o;
    logic [1:0] fifo_tag_o;
    logic [W-1:0] fifo_word_o;

    wbc_burst_coalescer #(.W(W), .MAX_BEATS(16), .FREEW(FREEW)) u0 (
        .clk(clk), .rst_n(rst_n), .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i),
        .wb_we_i(wb_we_i), .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i),
        .wb_seq_i(wb_seq_i), .wb_ack_o(wb_ack_o), .fifo_free_i(fifo_free_i),
        .fifo_push_o(fifo_push_o), .fifo_tag_o(fifo_tag_o), .fifo_word_o(fifo_word_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc_cnt = 0;
    always @(posedge clk) cyc_cnt++;

    logic [1:0]   log_tag  [0:511];
    logic [W-1:0] log_word [0:511];
    int           log_cyc  [0:511];
    int           n_log = 0;
    always @(negedge clk) if (rst_n && fifo_push_o && n_log < 512) begin
        log_tag[n_log]  = fifo_tag_o;
        log_word[n_log] = fifo_word_o;
        log_cyc[n_log]  = cyc_cnt;
        n_log++;
    end

    int checks = 0, fails = 0;

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_entry(string req, int idx, logic [1:0] tag, logic [W-1:0] word);
        chk({req, " tag"}, W'(log_tag[idx]), W'(tag));
        chk({req, " word"}, log_word[idx], word);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [W-1:0] adr, logic [W-1:0] dat, logic seq, output int acyc);
        int guard = 0;
        wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = 1;
        wb_adr_i = adr; wb_dat_i = dat; wb_seq_i = seq;
        acyc = -1;
        while (acyc < 0 && guard < 200) begin
            @(negedge clk);
            if (wb_ack_o) acyc = cyc_cnt;
            step();
            guard++;
        end
        wb_stb_i = 0;
        if (acyc < 0) chk("write ack timeout", 0, 1);
    endtask

    task automatic end_cyc();
        wb_cyc_i = 0; wb_stb_i = 0;
        repeat (3) step();
    endtask

    task automatic t_reset();
        wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = 1;
        @(negedge clk);
        chk("R1 ack in reset", W'(wb_ack_o), 0);
        chk("R1 push in reset", W'(fifo_push_o), 0);
        wb_cyc_i = 0; wb_stb_i = 0; wb_we_i = 0;
        step(); rst_n = 1; step();
    endtask

    task automatic t_single();
        int base = n_log, a;
        wr(32'h100, 32'h11, 0, a);
        end_cyc();
        chk("R2 entry count", W'(n_log - base), 2);
        chk_entry("R2 addr", base, 2'b01, 32'h100);
        chk_entry("R2 last", base + 1, 2'b11, 32'h11);
        chk("R2 addr cycle", W'(log_cyc[base]), W'(a));
        chk("R2 last cycle", W'(log_cyc[base + 1]), W'(a + 1));
    endtask

    task automatic t_burst();
        int base = n_log, a[4];
        for (int i = 0; i < 4; i++) wr(32'h200 + 4 * i, 32'hD0 + i, 1, a[i]);
        wb_cyc_i = 0;
        repeat (3) step();
        chk("R3 entry count", W'(n_log - base), 5);
        chk_entry("R3 addr", base, 2'b01, 32'h200);
        for (int i = 0; i < 3; i++) chk_entry("R3 cont", base + 1 + i, 2'b10, 32'hD0 + i);
        chk("R3 back-to-back ack", W'(a[3] - a[0]), 3);
        chk("R3 cont cycle", W'(log_cyc[base + 2]), W'(a[2]));
        chk_entry("R7 last", base + 4, 2'b11, 32'hD3);
        chk("R7 last cycle", W'(log_cyc[base + 4]), W'(a[3] + 1));
    endtask

    task automatic t_break();
        int base = n_log, a0, a1, a2;
        wr(32'h300, 32'hA0, 1, a0);
        wr(32'h304, 32'hA1, 1, a1);
        wr(32'h400, 32'hA2, 1, a2);
        end_cyc();
        chk("R4 entry count", W'(n_log - base), 5);
        chk_entry("R4 first addr", base, 2'b01, 32'h300);
        chk_entry("R4 cont", base + 1, 2'b10, 32'hA0);
        chk_entry("R4 close", base + 2, 2'b11, 32'hA1);
        chk_entry("R4 new addr", base + 3, 2'b01, 32'h400);
        chk_entry("R4 new last", base + 4, 2'b11, 32'hA2);
        chk("R4 wait state", W'(a2 - a1), 2);
        chk("R4 close cycle", W'(log_cyc[base + 2]), W'(a1 + 1));
    endtask

    task automatic t_unflag();
        int base = n_log, a0, a1;
        wr(32'h500, 32'hB0, 1, a0);
        wr(32'h504, 32'hB1, 0, a1);
        end_cyc();
        chk("R5 entry count", W'(n_log - base), 4);
        chk_entry("R5 close", base + 1, 2'b11, 32'hB0);
        chk_entry("R5 single addr", base + 2, 2'b01, 32'h504);
        chk_entry("R5 single last", base + 3, 2'b11, 32'hB1);
        chk("R5 wait state", W'(a1 - a0), 2);
    endtask

    task automatic t_max();
        int base = n_log, a[17];
        for (int i = 0; i < 17; i++) wr(32'h1000 + 4 * i, 32'hC0 + i, 1, a[i]);
        end_cyc();
        chk("R6 entry count", W'(n_log - base), 19);
        chk_entry("R6 addr", base, 2'b01, 32'h1000);
        chk_entry("R6 cont 15", base + 15, 2'b10, 32'hCE);
        chk_entry("R6 last", base + 16, 2'b11, 32'hCF);
        chk("R6 last cycle", W'(log_cyc[base + 16]), W'(a[15] + 1));
        chk_entry("R6 new addr", base + 17, 2'b01, 32'h1040);
        chk_entry("R6 new last", base + 18, 2'b11, 32'hD0);
    endtask

    task automatic t_free();
        int base = n_log;
        fifo_free_i = 6'd1;
        wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = 1; wb_seq_i = 1;
        wb_adr_i = 32'h2000; wb_dat_i = 32'hE0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8 stall ack", W'(wb_ack_o), 0);
            step();
        end
        chk("R8 stall no push", W'(n_log - base), 0);
        fifo_free_i = 6'd2;
        @(negedge clk);
        chk("R8 accept ack", W'(wb_ack_o), 1);
        step();
        wb_stb_i = 0; fifo_free_i = 6'd1;
        step();
        chk("R8 entry count", W'(n_log - base), 2);
        chk_entry("R8 addr", base, 2'b01, 32'h2000);
        chk_entry("R8 low-room close", base + 1, 2'b11, 32'hE0);
        fifo_free_i = 6'd16;
        end_cyc();
    endtask

    task automatic t_ignore();
        int base = n_log;
        wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = 0;
        repeat (3) begin @(negedge clk); chk("R9 read ack", W'(wb_ack_o), 0); step(); end
        wb_cyc_i = 0; wb_we_i = 1;
        repeat (3) begin @(negedge clk); chk("R9 no-cyc ack", W'(wb_ack_o), 0); step(); end
        chk("R9 no push", W'(n_log - base), 0);
        end_cyc();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        step(); step();
        t_reset();
        t_single();
        t_burst();
        t_break();
        t_unflag();
        t_max();
        t_free();
        t_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule